// File: doc/BRIEF.md
# Transmit Link Bring-Up Sequencer

This block steers one serial-converter transmit link from reset to user data. It starts in code group synchronization (CGS), where every lane cycle carries four comma (K28.5) characters. It then sends the initial lane alignment sequence (ILAS), a programmable run of multiframes framed by start and end markers. Finally it hands the lane to user data. Each lane cycle carries four octets. The block produces one symbol-type code per cycle, and the downstream octet builder, encoder and scrambler act on that code.

The block decides when to move between states. It watches the receiver's active-low synchronization request, a tick that marks the last cycle of each local multiframe, a flag that says the shared timing reference has been sampled, and a set of control inputs. Software can restart the link with a self-clearing request. A loop test holds the link in ILAS, and a D21.5 test state overrides everything else. The current state and the live ILAS multiframe index are reported on the outputs.

States are CGS, ILAS, DATA and TEST. The transitions are:
- CGS→ILAS or CGS→DATA on exit.
- ILAS→DATA after the last multiframe.
- ILAS/DATA→CGS on a sync request.
- Any state→CGS on a software restart.
- Any state→TEST while the test input is high.
- TEST→CGS when it is released.

Top module: `jtx_link_fsm`

## Requirements
- R1: After reset the block is in CGS with `ilas_mf_cnt` 0, `reinit_pending` 0 and the comma code on `sym_sel`.
- R2: `link_state` encodes CGS=00, ILAS=01, DATA=10, TEST=11. `sym_sel` codes are: 0 comma, 1 ILAS start /R/, 2 ILAS link configuration, 3 ILAS filler, 4 ILAS end /A/, 5 user data, 6 D21.5. CGS always gives 0, DATA gives 5 and TEST gives 6.
- R3: `ilas_len_m1` holds the ILAS length minus one. A value of 3 or more gives `ilas_len_m1`+1 multiframes. Values 0, 1 and 2 give four multiframes. `ilas_mf_cnt` shows the index of the current ILAS multiframe starting from 0, and is 0 outside ILAS.
- R4: CGS is never left while both `sysref_seen` and `sysref_bypass` are low.
- R5: CGS is left only at the end of a cycle in which `lmfc_tick` is high, and only once the link has spent at least MIN_CGS_CYCLES cycles in CGS, counting that cycle. After reset or a sync request, exit also needs `sync_n` high in that cycle.
- R6: In ILAS, the first cycle after a tick carries code 1 and a cycle with `lmfc_tick` high carries code 4. The second cycle of multiframe index 1 carries code 2. Every other ILAS cycle carries code 3.
- R7: `sync_n` low in ILAS or DATA sends the link to CGS on the next cycle.
- R8: A `reinit_set` pulse sets `reinit_pending`. While pending, and outside TEST, the link goes back to CGS on the next cycle and the pending bit clears. A new `reinit_set` wins over the clear.
- R9: A restart taken with `sync_n` high is a software entry. By default it leaves CGS without regard to `sync_n`. With `exit_on_sync_rise` set, it waits in CGS until a rising edge of `sync_n` is seen there.
- R10: With `lane_sync_en` low and `ilas_loop` low, CGS exits straight to DATA.
- R11: With `ilas_loop` high, the CGS exit always goes to ILAS. The link then stays in ILAS, and `ilas_mf_cnt` wraps to 0 after the last multiframe.
- R12: `test_d215` high moves the link to TEST on the next cycle from any state. Its release restarts CGS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | 1 | Receiver synchronization request, low = request |
| lmfc_tick | input | 1 | High in the last cycle of each local multiframe |
| sysref_seen | input | 1 | Timing reference has been sampled |
| reinit_set | input | 1 | Write-1 pulse requesting link restart |
| ilas_len_m1 | input | CNT_W | ILAS multiframes minus one |
| ilas_loop | input | 1 | ILAS loop test enable |
| lane_sync_en | input | 1 | Lane alignment enable (ILAS used) |
| exit_on_sync_rise | input | 1 | Software entry waits for a sync rise |
| sysref_bypass | input | 1 | Leave CGS without a sampled timing reference |
| test_d215 | input | 1 | Force D21.5 test state |
| link_state | output | 2 | Current state |
| ilas_mf_cnt | output | CNT_W | Current ILAS multiframe index, minus-one form |
| sym_sel | output | 3 | Symbol type for this cycle |
| reinit_pending | output | 1 | Software restart requested, not yet taken |

## Verification
A behavioural model runs alongside the design and is compared on every cycle. It is driven through several stimulus patterns:
- A clean bring-up with the timing reference missing and then present separates the R4 gate from the R5 tick alignment.
- Forced relinks with ILAS lengths of 0 and 5 separate clamping from plain minus-one counting.
- Software restarts, with the sync line held high, with it dropped low, and with a pulse in rise mode, tell the three CGS exit conditions apart.
- Lane sync off, loop test and the D21.5 override each check a path the normal bring-up never takes.

// File: rtl/jtx_pkg.sv
package jtx_pkg;

    typedef enum logic [1:0] {
        ST_CGS  = 2'b00,
        ST_ILAS = 2'b01,
        ST_DATA = 2'b10,
        ST_TEST = 2'b11
    } link_state_t;

    typedef enum logic [2:0] {
        SYM_COMMA   = 3'd0,
        SYM_ILAS_R  = 3'd1,
        SYM_ILAS_CF = 3'd2,
        SYM_ILAS_FL = 3'd3,
        SYM_ILAS_A  = 3'd4,
        SYM_USER    = 3'd5,
        SYM_D215    = 3'd6
    } sym_t;

    localparam int ILAS_MIN_M1 = 3;

endpackage

// File: rtl/jtx_mf_pos.sv
// Tracks the cycle position inside the current multiframe (0, 1, 2+).
module jtx_mf_pos (
    input  logic clk,
    input  logic rst_n,
    input  logic lmfc_tick,
    output logic first_beat,
    output logic second_beat
);
    logic [1:0] beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            beat_q <= 2'd0;
        else if (lmfc_tick)
            beat_q <= 2'd0;
        else if (beat_q != 2'd2)
            beat_q <= beat_q + 2'd1;
    end

    assign first_beat  = (beat_q == 2'd0);
    assign second_beat = (beat_q == 2'd1);
endmodule

// File: rtl/jtx_ilas_counter.sv
// Multiframe counter for ILAS, minus-one form, with length clamping.
module jtx_ilas_counter
    import jtx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             lmfc_tick,
    input  logic [CNT_W-1:0] len_m1,
    output logic [CNT_W-1:0] cnt,
    output logic             last_mf
);
    localparam logic [CNT_W-1:0] FLOOR_M1 = CNT_W'(ILAS_MIN_M1);

    logic [CNT_W-1:0] eff_m1;
    logic [CNT_W-1:0] cnt_q;

    assign eff_m1  = (len_m1 < FLOOR_M1) ? FLOOR_M1 : len_m1;
    assign last_mf = (cnt_q == eff_m1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (lmfc_tick)
            cnt_q <= last_mf ? '0 : cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/jtx_cgs_timer.sv
// Counts cycles spent in CGS; flags when the minimum dwell is reached.
module jtx_cgs_timer #(
    parameter int MIN_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic keep,
    output logic min_met
);
    localparam int W = $clog2(MIN_CYCLES) + 1;
    localparam logic [W-1:0] LIMIT = W'(MIN_CYCLES - 1);

    logic [W-1:0] cyc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !keep)
            cyc_q <= '0;
        else if (cyc_q != LIMIT)
            cyc_q <= cyc_q + 1'b1;
    end

    assign min_met = (cyc_q >= LIMIT);
endmodule

// File: rtl/jtx_sync_watch.sv
// Detects a rising edge of the sync line and remembers it during a CGS stay.
module jtx_sync_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    input  logic keep,
    output logic rise_ok
);
    logic sync_q;
    logic seen_q;
    logic rise;

    assign rise = sync_n & ~sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b1;
            seen_q <= 1'b0;
        end else begin
            sync_q <= sync_n;
            seen_q <= keep ? (seen_q | rise) : 1'b0;
        end
    end

    assign rise_ok = seen_q | rise;
endmodule

// File: rtl/jtx_link_fsm.sv
module jtx_link_fsm
    import jtx_pkg::*;
#(
    parameter int CNT_W          = 8,
    parameter int MIN_CGS_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n,
    input  logic             lmfc_tick,
    input  logic             sysref_seen,
    input  logic             reinit_set,
    input  logic [CNT_W-1:0] ilas_len_m1,
    input  logic             ilas_loop,
    input  logic             lane_sync_en,
    input  logic             exit_on_sync_rise,
    input  logic             sysref_bypass,
    input  logic             test_d215,
    output logic [1:0]       link_state,
    output logic [CNT_W-1:0] ilas_mf_cnt,
    output logic [2:0]       sym_sel,
    output logic             reinit_pending
);
    link_state_t      state_q, state_d;
    logic             pend_q, soft_q;
    logic             restart;
    logic             exit_ok;
    logic             sync_gate;
    logic             ref_ok;
    logic             cgs_keep, ilas_run;
    logic             min_met, rise_ok;
    logic             first_beat, second_beat;
    logic             last_mf;
    logic [CNT_W-1:0] mf_cnt;
    sym_t             sym;

    jtx_mf_pos u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .lmfc_tick   (lmfc_tick),
        .first_beat  (first_beat),
        .second_beat (second_beat)
    );

    jtx_ilas_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ilas_run),
        .lmfc_tick (lmfc_tick),
        .len_m1    (ilas_len_m1),
        .cnt       (mf_cnt),
        .last_mf   (last_mf)
    );

    jtx_cgs_timer #(.MIN_CYCLES(MIN_CGS_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .keep    (cgs_keep),
        .min_met (min_met)
    );

    jtx_sync_watch u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_n  (sync_n),
        .keep    (cgs_keep),
        .rise_ok (rise_ok)
    );

    // CGS exit qualification
    assign ref_ok    = sysref_seen | sysref_bypass;
    assign sync_gate = soft_q ? (!exit_on_sync_rise || rise_ok) : sync_n;
    assign exit_ok   = lmfc_tick && min_met && ref_ok && sync_gate;

    // Next-state logic
    always_comb begin
        restart = 1'b0;
        state_d = state_q;
        if (test_d215) begin
            state_d = ST_TEST;
        end else begin
            unique case (state_q)
                ST_CGS: begin
                    if (pend_q)
                        restart = 1'b1;
                    else if (exit_ok)
                        state_d = (ilas_loop || lane_sync_en) ? ST_ILAS : ST_DATA;
                end
                ST_ILAS: begin
                    if (pend_q || !sync_n)
                        restart = 1'b1;
                    else if (lmfc_tick && last_mf && !ilas_loop)
                        state_d = ST_DATA;
                end
                ST_DATA: begin
                    if (pend_q || !sync_n)
                        restart = 1'b1;
                end
                ST_TEST: restart = 1'b1;
            endcase
            if (restart)
                state_d = ST_CGS;
        end
    end

    assign cgs_keep = (state_q == ST_CGS) && (state_d == ST_CGS) && !restart;
    assign ilas_run = (state_q == ST_ILAS) && (state_d == ST_ILAS);

    // State and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CGS;
            pend_q  <= 1'b0;
            soft_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= reinit_set | (pend_q & ~restart);
            if (restart)
                soft_q <= pend_q & sync_n;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_CGS:  sym = SYM_COMMA;
            ST_DATA: sym = SYM_USER;
            ST_TEST: sym = SYM_D215;
            ST_ILAS: begin
                if (lmfc_tick)
                    sym = SYM_ILAS_A;
                else if (first_beat)
                    sym = SYM_ILAS_R;
                else if (second_beat && mf_cnt == CNT_W'(1))
                    sym = SYM_ILAS_CF;
                else
                    sym = SYM_ILAS_FL;
            end
        endcase
    end

    assign link_state     = state_q;
    assign ilas_mf_cnt    = mf_cnt;
    assign sym_sel        = sym;
    assign reinit_pending = pend_q;
endmodule

// File: rtl/jtx_link_fsm_chk.sv
module jtx_link_fsm_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_n,
    input logic             lmfc_tick,
    input logic             sysref_seen,
    input logic             reinit_set,
    input logic             ilas_loop,
    input logic             lane_sync_en,
    input logic             sysref_bypass,
    input logic             test_d215,
    input logic [1:0]       link_state,
    input logic [CNT_W-1:0] ilas_mf_cnt,
    input logic             reinit_pending
);
    AST_REF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'b00 && !sysref_seen && !sysref_bypass && !test_d215) |=> link_state == 2'b00); // R4

    AST_TICK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'b00 && !lmfc_tick && !test_d215) |=> link_state == 2'b00); // R5

    AST_SYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((link_state == 2'b01 || link_state == 2'b10) && !sync_n && !test_d215) |=> link_state == 2'b00); // R7

    AST_REINIT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit_pending && link_state != 2'b11 && !test_d215 && !reinit_set) |=> (!reinit_pending && link_state == 2'b00)); // R8

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state != 2'b01) |-> ilas_mf_cnt == '0); // R3

    AST_NO_ILAS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'b00 && !lane_sync_en && !ilas_loop) |=> link_state != 2'b01); // R10

    AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 2'b01 && ilas_loop && sync_n && !reinit_pending && !test_d215) |=> link_state == 2'b01); // R11

    AST_TEST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        test_d215 |=> link_state == 2'b11); // R12
endmodule

bind jtx_link_fsm jtx_link_fsm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sync_n         (sync_n),
    .lmfc_tick      (lmfc_tick),
    .sysref_seen    (sysref_seen),
    .reinit_set     (reinit_set),
    .ilas_loop      (ilas_loop),
    .lane_sync_en   (lane_sync_en),
    .sysref_bypass  (sysref_bypass),
    .test_d215      (test_d215),
    .link_state     (link_state),
    .ilas_mf_cnt    (ilas_mf_cnt),
    .reinit_pending (reinit_pending)
);

// File: tb/jtx_link_fsm_bench.sv
module jtx_link_fsm_bench;
    localparam int CNT_W = 8;
    localparam int MINC  = 2;
    localparam int MF    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_n = 1'b1, sysref_seen = 1'b0, reinit_set = 1'b0;
    logic [CNT_W-1:0] ilas_len_m1 = 8'd3;
    logic ilas_loop = 1'b0, lane_sync_en = 1'b1, exit_on_sync_rise = 1'b0;
    logic sysref_bypass = 1'b0, test_d215 = 1'b0;
    logic lmfc_tick;
    logic [1:0] link_state;
    logic [CNT_W-1:0] ilas_mf_cnt;
    logic [2:0] sym_sel;
    logic reinit_pending;

    int n_run = 0, n_fail = 0;
    int phase = 0;
    int ilas_cyc = 0, cfg_cnt = 0;
    string cur_tag = "R2";
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) phase <= 0;
        else phase <= (phase == MF - 1) ? 0 : phase + 1;
    end
    assign lmfc_tick = (phase == MF - 1);

    jtx_link_fsm #(.CNT_W(CNT_W), .MIN_CGS_CYCLES(MINC)) u_jtx_link_fsm (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .lmfc_tick(lmfc_tick),
        .sysref_seen(sysref_seen), .reinit_set(reinit_set), .ilas_len_m1(ilas_len_m1),
        .ilas_loop(ilas_loop), .lane_sync_en(lane_sync_en),
        .exit_on_sync_rise(exit_on_sync_rise), .sysref_bypass(sysref_bypass),
        .test_d215(test_d215), .link_state(link_state), .ilas_mf_cnt(ilas_mf_cnt),
        .sym_sel(sym_sel), .reinit_pending(reinit_pending)
    );

    // Behavioural reference model
    int m_st = 0, m_cnt = 0, m_pend = 0, m_soft = 0, m_seen = 0, m_prev = 1, m_dwell = 0, m_beat = 0;

    always @(posedge clk) begin
        int eff, nx, rs, rise, ok;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pend = 0; m_soft = 0; m_seen = 0; m_prev = 1; m_dwell = 0; m_beat = 0;
        end else begin
            eff  = (ilas_len_m1 < 3) ? 3 : int'(ilas_len_m1);
            rise = (sync_n && !m_prev) ? 1 : 0;
            rs = 0; nx = m_st;
            if (test_d215) nx = 3;
            else if (m_st == 3) rs = 1;
            else if (m_pend) rs = 1;
            else if ((m_st == 1 || m_st == 2) && !sync_n) rs = 1;
            else if (m_st == 0) begin
                ok = (m_dwell >= MINC - 1) && lmfc_tick && (sysref_seen || sysref_bypass);
                if (m_soft) ok = ok && (!exit_on_sync_rise || m_seen || rise);
                else ok = ok && sync_n;
                if (ok) nx = (ilas_loop || lane_sync_en) ? 1 : 2;
            end else if (m_st == 1 && lmfc_tick && m_cnt == eff && !ilas_loop) nx = 2;
            if (rs) nx = 0;
            if (m_st == 1 && nx == 1) begin
                if (lmfc_tick) m_cnt = (m_cnt == eff) ? 0 : m_cnt + 1;
            end else m_cnt = 0;
            if (m_st == 0 && nx == 0 && !rs) begin
                if (m_dwell < MINC) m_dwell++;
                if (rise) m_seen = 1;
            end else begin
                m_dwell = 0; m_seen = 0;
            end
            if (rs) m_soft = (m_pend && sync_n) ? 1 : 0;
            m_pend = (reinit_set || (m_pend && !rs)) ? 1 : 0;
            m_prev = sync_n;
            m_beat = lmfc_tick ? 0 : ((m_beat < 2) ? m_beat + 1 : 2);
            m_st = nx;
        end
    end

    function automatic int exp_sym();
        if (m_st == 0) return 0;
        if (m_st == 2) return 5;
        if (m_st == 3) return 6;
        if (lmfc_tick) return 4;
        if (m_beat == 0) return 1;
        if (m_beat == 1 && m_cnt == 1) return 2;
        return 3;
    endfunction

    task automatic check(string tag, int act, int expv, string what);
        n_run++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_tag, int'(link_state), m_st, "state");
            check(cur_tag, int'(ilas_mf_cnt), m_cnt, "ilas_cnt");
            check(cur_tag, int'(sym_sel), exp_sym(), "sym");
            check(cur_tag, int'(reinit_pending), m_pend, "pending");
            if (link_state == 2'b01) ilas_cyc++;
            if (sym_sel == 3'd2) cfg_cnt++;
        end
    end

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wait_state(int s, int lim, string tag);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (int'(link_state) == s) return;
        end
        check(tag, int'(link_state), s, "state reached");
    endtask

    task automatic relink(string tag);
        ilas_cyc = 0; cfg_cnt = 0;
        sync_n = 1'b0; cyc(2);
        sync_n = 1'b1;
        wait_state(2, 300, tag);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(link_state), 0, "reset state");
        check("R1", int'(ilas_mf_cnt), 0, "reset cnt");
        check("R1", int'(sym_sel), 0, "reset sym");
        check("R1", int'(reinit_pending), 0, "reset pending");
        #2;
        // R4: no sampled timing reference keeps CGS
        cur_tag = "R4";
        cyc(20);
        @(negedge clk); check("R4", int'(link_state), 0, "held in CGS"); #2;
        // R3/R5/R6: normal bring-up with four multiframes
        cur_tag = "R5";
        ilas_cyc = 0; cfg_cnt = 0;
        sysref_seen = 1'b1;
        wait_state(2, 100, "R5"); #1;
        check("R3", ilas_cyc, 4 * MF, "ilas cycles len3");
        check("R6", cfg_cnt, 1, "config beats");
        cyc(3);
        // R7: sync request from DATA
        cur_tag = "R7";
        sync_n = 1'b0; cyc(1);
        @(negedge clk); check("R7", int'(link_state), 0, "back to CGS"); #2;
        cyc(4); sync_n = 1'b1;
        wait_state(2, 100, "R7"); #1;
        // R3 clamp and longer length
        cur_tag = "R3";
        ilas_len_m1 = 8'd0; relink("R3");
        check("R3", ilas_cyc, 4 * MF, "clamped len0");
        ilas_len_m1 = 8'd5; relink("R3");
        check("R3", ilas_cyc, 6 * MF, "len5");
        ilas_len_m1 = 8'd3;
        // R8/R9: software restart in rise mode
        cur_tag = "R9";
        exit_on_sync_rise = 1'b1;
        reinit_set = 1'b1; cyc(1); reinit_set = 1'b0;
        cyc(1);
        @(negedge clk);
        check("R8", int'(reinit_pending), 0, "pending cleared");
        check("R8", int'(link_state), 0, "restart to CGS");
        #2; cyc(30);
        @(negedge clk); check("R9", int'(link_state), 0, "waits for rise"); #2;
        sync_n = 1'b0; cyc(2); sync_n = 1'b1;
        wait_state(2, 100, "R9"); #1;
        // R9 default mode: leaves CGS with sync low
        exit_on_sync_rise = 1'b0;
        reinit_set = 1'b1; cyc(1); reinit_set = 1'b0;
        cyc(1); sync_n = 1'b0;
        wait_state(1, 40, "R9"); #1;
        sync_n = 1'b1; cyc(2);
        wait_state(2, 100, "R9"); #1;
        // R4 bypass
        cur_tag = "R4";
        sysref_seen = 1'b0; sysref_bypass = 1'b1;
        relink("R4");
        sysref_bypass = 1'b0; sysref_seen = 1'b1;
        // R10 lane sync off
        cur_tag = "R10";
        lane_sync_en = 1'b0;
        relink("R10");
        check("R10", ilas_cyc, 0, "no ILAS cycles");
        lane_sync_en = 1'b1;
        // R11 loop test
        cur_tag = "R11";
        ilas_loop = 1'b1;
        sync_n = 1'b0; cyc(2); sync_n = 1'b1;
        cyc(60);
        @(negedge clk); check("R11", int'(link_state), 1, "held in ILAS"); #2;
        ilas_loop = 1'b0;
        wait_state(2, 100, "R11"); #1;
        // R12 test override
        cur_tag = "R12";
        test_d215 = 1'b1; cyc(5);
        @(negedge clk);
        check("R12", int'(link_state), 3, "test state");
        check("R12", int'(sym_sel), 6, "d21.5 sym");
        #2; test_d215 = 1'b0; cyc(1);
        @(negedge clk); check("R12", int'(link_state), 0, "release to CGS"); #2;
        wait_state(2, 100, "R12");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule